// File: doc/BRIEF.md
# I2C Slave Controller

This block is a byte-oriented I2C target for a 7-bit address. It watches the open-drain SCL and SDA lines, which it sees as filtered inputs and drives through output enables. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block compares the first byte after a START with its programmed address. On a write, each data byte goes into a one-byte receive register. On a read, bytes come out of a small transmit FIFO, most significant bit first. Software uses a four-word register port to set up the block, load transmit bytes and collect received bytes.

The block never leaves a bus line held low. If a read is addressed to it while the transmit FIFO is empty and stretching is off, it answers NACK and lets the master end the transfer. Clearing the enable releases both lines at once. A change to the stretch setting takes effect only while SCL is low or the block is idle, so it cannot make a short pulse on SCL. When stretching is on, the block holds SCL low in two cases: while a received byte is still unread, and before a transmit byte when the FIFO is empty.

Top module: `i2c_target`

## Requirements
- R1: After reset, neither SCL nor SDA is driven, and the status word (offset 2) reads 0x02. Status bits: bit0 receive full, bit1 transmit empty, bit2 transmit full, bit6 busy.
- R2: Offset 1 holds the 7-bit own address. When bits 7:1 of the first byte after a START equal it, the block drives ACK in the ninth clock. Any other address gets no ACK.
- R3: In a write, data bits are sampled on SCL rising edges and the byte is ACKed. The byte can then be read at offset 3, which clears the receive-full flag. A byte that arrives while the flag is still set gets a NACK and does not replace the held byte.
- R4: Writing offset 3 pushes a byte into the transmit FIFO. In a read, each byte is popped and sent MSB first. A master ACK asks for the next byte, and a master NACK ends the sending.
- R5: A read addressed to the block while the transmit FIFO is empty and stretching is off gets a NACK, and SDA is left released.
- R6: The busy flag (status bit6) sets on an address match. It clears on STOP, and also on a repeated START followed by a non-matching address.
- R7: Clearing control bit0 (enable) at any time releases SDA and SCL and clears busy within two clocks.
- R8: With control bit6 (stretch) set, SCL is held low after the ACK of a received byte until offset 3 is read. SCL is also held low before a transmit byte until the FIFO is not empty. A read into an empty FIFO is then ACKed.
- R9: The block starts driving SDA low only while SCL is low, and starts holding SCL only while SCL is already low.
- R10: The transmit FIFO holds TX_DEPTH bytes. When it is full, status bit2 is set and further writes to offset 3 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive byte at offset 3) |
| reg_addr | input | 2 | Register offset: 0 control, 1 own address, 2 status, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
A bit counter that has drifted or a wrong phase state shows within one byte, as a missing or misplaced ACK, or as a wrong read byte that the scoreboard catches when the master finishes the byte. A stale stretch or enable state shows a few clocks after the SCL falling edge: scl_oe or sda_oe stays asserted when it should not. A busy flag or FIFO count that no longer matches the bus shows on the next status read.

// File: rtl/i2c_target.sv
`timescale 1ns/1ps
module i2c_target #(
  parameter int TX_DEPTH = 4,
  parameter int SYNC_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int PW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int CW = $clog2(TX_DEPTH + 1);

  typedef enum logic [3:0] {S_IDLE, S_ADDR, S_RX, S_ACK, S_RXHOLD, S_LOAD, S_TX, S_TXACK, S_WAIT} st_t;

  st_t st;
  logic [SYNC_LEN-1:0] scl_s, sda_s;
  logic scl_q, sda_q, scl_d, sda_d;
  logic en, str_req, str_act, busy, rw, mack, byte_done, rx_full, sda_drv;
  logic [6:0] own;
  logic [7:0] sh, rx_hold;
  logic [2:0] cnt;
  logic [7:0] mem [TX_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt_f;

  wire tx_empty  = (cnt_f == '0);
  wire tx_full   = (cnt_f == CW'(TX_DEPTH));
  wire scl_rise  = scl_q & ~scl_d;
  wire scl_fall  = ~scl_q & scl_d;
  wire start_det = en & scl_q & scl_d & sda_d & ~sda_q;
  wire stop_det  = en & scl_q & scl_d & ~sda_d & sda_q;
  wire bus_evt   = ~en | start_det | stop_det;
  wire tx_push   = reg_wr && reg_addr == 2'd3 && !tx_full;
  wire tx_pop    = st == S_LOAD && !tx_empty && !bus_evt;
  wire rx_pop    = reg_rd && reg_addr == 2'd3;
  wire [7:0] tx_head = mem[rp];

  assign sda_oe = sda_drv;
  assign scl_oe = en & str_act & ((st == S_RXHOLD & rx_full) | (st == S_LOAD & tx_empty));

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {1'b0, str_req, 5'b0, en};
      2'd1:    reg_rdata = {1'b0, own};
      2'd2:    reg_rdata = {1'b0, busy, 3'b0, tx_full, tx_empty, rx_full};
      default: reg_rdata = rx_hold;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1;
      scl_q <= 1'b1; sda_q <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[SYNC_LEN-2:0], scl_i};
      sda_s <= {sda_s[SYNC_LEN-2:0], sda_i};
      if (scl_s[SYNC_LEN-1] == scl_s[SYNC_LEN-2]) scl_q <= scl_s[SYNC_LEN-1];
      if (sda_s[SYNC_LEN-1] == sda_s[SYNC_LEN-2]) sda_q <= sda_s[SYNC_LEN-1];
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; str_req <= 1'b0; str_act <= 1'b0; own <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) begin
        en      <= reg_wdata[0];
        str_req <= reg_wdata[6];
      end
      if (reg_wr && reg_addr == 2'd1) own <= reg_wdata[6:0];
      if (!scl_q || st == S_IDLE) str_act <= str_req;
    end
  end

  always_ff @(posedge clk) if (tx_push) mem[wp] <= reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt_f <= '0;
    end else begin
      if (tx_push) wp <= (wp == PW'(TX_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (tx_pop)  rp <= (rp == PW'(TX_DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt_f <= cnt_f + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sda_drv <= 1'b0; busy <= 1'b0; rw <= 1'b0; mack <= 1'b0;
      byte_done <= 1'b0; cnt <= '0; sh <= '0; rx_hold <= '0; rx_full <= 1'b0;
    end else begin
      if (rx_pop) rx_full <= 1'b0;
      if (!en || stop_det) begin
        st <= S_IDLE; sda_drv <= 1'b0; busy <= 1'b0;
      end else if (start_det) begin
        st <= S_ADDR; cnt <= '0; byte_done <= 1'b0; sda_drv <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && !byte_done) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (st == S_ADDR) begin
                if (sh[7:1] == own && !(sh[0] && tx_empty && !str_act)) begin
                  sda_drv <= 1'b1; busy <= 1'b1; rw <= sh[0]; st <= S_ACK;
                end else begin
                  busy <= 1'b0; st <= S_WAIT;
                end
              end else if (!rx_full) begin
                rx_hold <= sh; rx_full <= 1'b1; sda_drv <= 1'b1; st <= S_ACK;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            sda_drv <= 1'b0; cnt <= '0;
            st <= rw ? S_LOAD : S_RXHOLD;
          end
          S_RXHOLD: if (!(rx_full && str_act)) st <= S_RX;
          S_LOAD: begin
            if (!tx_empty) begin
              sh <= tx_head; sda_drv <= ~tx_head[7]; cnt <= '0; st <= S_TX;
            end else if (!str_act) begin
              sh <= 8'hFF; sda_drv <= 1'b0; cnt <= '0; st <= S_TX;
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall) begin
              if (byte_done) begin
                byte_done <= 1'b0; sda_drv <= 1'b0; st <= S_TXACK;
              end else begin
                sh <= {sh[6:0], 1'b1}; sda_drv <= ~sh[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) mack <= ~sda_q;
            else if (scl_fall) st <= mack ? S_LOAD : S_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_sda_low_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drv) |-> !scl_q);
  a_r9_stretch_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_q);
  a_r7_disable_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sda_oe && !scl_oe && !busy));
  a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !busy));
  a_r6_busy_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sda_drv);
  a_r5_empty_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st == S_ADDR && scl_fall && byte_done && sh[0] && tx_empty && !str_act) |=> (!sda_drv && st == S_WAIT));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_f <= CW'(TX_DEPTH));
endmodule

// File: tb/tb_i2c_target.sv
`timescale 1ns/1ps
module tb_i2c_target;
  localparam int T = 40;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic scl_oe, sda_oe;
  logic [7:0] reg_rdata;
  wire scl_i = scl_m & ~scl_oe;
  wire sda_i = sda_m & ~sda_oe;
  int checks = 0, errors = 0, r9_viol = 0;
  int exp_q[$], obs_q[$];
  string tag_q[$];
  logic prev_sda_oe = 0;
  logic done = 0;

  always #10 clk = ~clk;

  i2c_target dut (.clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic expect_byte(string tag, int v);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    prev_sda_oe <= sda_oe;
    if (sda_oe && !prev_sda_oe && scl_i) r9_viol <= r9_viol + 1;
    if (obs_q.size() > 0 && exp_q.size() > 0) begin
      automatic int o = obs_q.pop_front();
      automatic int e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, o, e);
    end
  end

  task automatic half(); repeat (T) @(negedge clk); endtask
  task automatic wait_scl(); while (scl_i == 1'b0) @(negedge clk); endtask

  task automatic m_start();
    repeat (4) @(negedge clk);
    sda_m = 1; half(); scl_m = 1; wait_scl(); half();
    sda_m = 0; half(); scl_m = 0;
  endtask

  task automatic m_stop();
    repeat (4) @(negedge clk);
    sda_m = 0; half(); scl_m = 1; wait_scl(); half(); sda_m = 1; half();
  endtask

  task automatic w_bit(logic b);
    repeat (4) @(negedge clk);
    sda_m = b; half(); scl_m = 1; wait_scl(); half(); scl_m = 0;
  endtask

  task automatic r_bit(output logic b);
    repeat (4) @(negedge clk);
    sda_m = 1; half(); scl_m = 1; wait_scl();
    repeat (T/2) @(negedge clk);
    b = sda_i;
    repeat (T/2) @(negedge clk);
    scl_m = 0;
  endtask

  task automatic w_byte(logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) w_bit(v[i]);
    r_bit(a);
    ack = ~a;
  endtask

  task automatic r_byte(logic m_ack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) r_bit(v[i]);
    w_bit(~m_ack);
    obs_q.push_back(int'(v));
  endtask

  task automatic rw(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rr(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    rr(2, d); chk("R1 status", d, 8'h02);

    rw(1, 8'h2A); rw(0, 8'h01);
    rr(1, d); chk("R2 own address", d, 8'h2A);

    m_start(); w_byte(8'h54, ack); chk("R2 address ack", ack, 1);
    rr(2, d); chk("R6 busy set", d[6], 1);
    w_byte(8'hA5, ack); chk("R3 data ack", ack, 1);
    m_stop();
    rr(2, d); chk("R6 busy clear on stop, R3 rx full", d, 8'h43 & 8'h03);
    rr(3, d); chk("R3 rx byte", d, 8'hA5);
    rr(2, d); chk("R3 rx flag cleared", d[0], 0);

    m_start(); w_byte(8'h2A, ack); chk("R2 other address nack", ack, 0);
    rr(2, d); chk("R6 not busy", d[6], 0);
    m_stop();

    m_start(); w_byte(8'h55, ack); chk("R5 empty read nack", ack, 0);
    repeat (10) @(negedge clk);
    chk("R5 sda released", sda_oe, 0);
    m_stop();

    rw(3, 8'h3C); rw(3, 8'hC3);
    m_start(); w_byte(8'h55, ack); chk("R4 read address ack", ack, 1);
    expect_byte("R4 first byte", 8'h3C); r_byte(1);
    expect_byte("R4 second byte", 8'hC3); r_byte(0);
    m_stop();
    rr(2, d); chk("R4 fifo drained", d, 8'h02);

    m_start(); w_byte(8'h54, ack); w_byte(8'h11, ack); chk("R3 first ack", ack, 1);
    w_byte(8'h22, ack); chk("R3 overrun nack", ack, 0);
    m_stop();
    rr(3, d); chk("R3 held byte kept", d, 8'h11);

    m_start(); w_byte(8'h54, ack); rr(2, d); chk("R6 busy before repeat", d[6], 1);
    m_start(); w_byte(8'h2A, ack); chk("R6 repeat other nack", ack, 0);
    rr(2, d); chk("R6 busy cleared by repeat", d[6], 0);
    m_stop();

    m_start();
    for (int i = 7; i >= 0; i--) w_bit(logic'((8'h54 >> i) & 1));
    repeat (10) @(negedge clk);
    chk("R7 ack driven before disable", sda_oe, 1);
    rw(0, 8'h00);
    repeat (1) @(negedge clk);
    chk("R7 sda released", sda_oe, 0);
    chk("R7 scl released", scl_oe, 0);
    rr(2, d); chk("R7 busy cleared", d[6], 0);
    r_bit(ack); chk("R7 no ack after disable", ack, 1);
    m_stop();

    rw(0, 8'h41);
    repeat (5) @(negedge clk);
    m_start(); w_byte(8'h54, ack); w_byte(8'h5A, ack); chk("R8 stretch write ack", ack, 1);
    repeat (20) @(negedge clk);
    chk("R8 scl held for rx", scl_oe, 1);
    rr(3, d); chk("R8 rx byte", d, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R8 scl released after read", scl_oe, 0);
    m_stop();

    m_start(); w_byte(8'h55, ack); chk("R8 empty read acked", ack, 1);
    repeat (20) @(negedge clk);
    chk("R8 scl held for tx", scl_oe, 1);
    rw(3, 8'h81);
    expect_byte("R8 stretched byte", 8'h81); r_byte(0);
    m_stop();
    chk("R8 scl free", scl_oe, 0);

    rw(0, 8'h01);
    for (int i = 1; i <= 5; i++) rw(3, 8'(i));
    rr(2, d); chk("R10 full flag", d, 8'h04);
    m_start(); w_byte(8'h55, ack);
    for (int i = 1; i <= 4; i++) begin
      expect_byte("R10 fifo byte", i);
      r_byte(i != 4);
    end
    m_stop();
    rr(2, d); chk("R10 extra write dropped", d, 8'h02);

    repeat (10) @(negedge clk);
    chk("R9 sda asserted only with scl low", r9_viol, 0);
    chk("R4 scoreboard drained", exp_q.size() + obs_q.size(), 0);
    done = 1;
    report();
    $finish;
  end
endmodule